// File: doc/BRIEF.md
# Sequenced Single-Fault Activation Controller

This block turns a set of faults that are already wired into one hardware configuration on and off, one at a time. A circular one-hot register produces the fault-enable vector. Each enable line drives one or both of two kinds of injection site. The first is a forcing gate on a circuit node: an OR gate gives a stuck-at-1 and an AND gate with an inverted enable gives a stuck-at-0. The second is a function-select cell. It holds a fault-free and a faulty 4-input function over the same inputs and picks the faulty one while its enable is high.

A test harness pulses `init_i` once to activate the first fault. It applies its full vector set and then pulses `advance_i` to move to the next fault. The position after the last one is the first one again. On that wrap `last_fault_o` pulses, so the harness knows every fault has had a pass.

A two-state machine sequences the register. In `ST_IDLE` (the reset state) no fault is active. The transition `IDLE_TO_RUN` is taken on `init_i`. In `ST_RUN` there are three transitions, and all of them stay in `ST_RUN`:
- `RUN_RELOAD` is taken on `init_i` and puts the register back to position 0.
- `RUN_STEP` is taken on `advance_i` when the register is not at the last position, and moves it one position on.
- `RUN_WRAP` is taken on `advance_i` when the register is at the last position, and returns it to position 0.

Top module: `fault_seq_top`

## Requirements
- R1: After reset, `fault_en_o` is all zero and `last_fault_o` is 0. Every `node_o[k]` equals `node_i[k]`, and `cell_o` equals bit `cell_in_i` of `GOOD_FN`.
- R2: One clock edge after a cycle with `init_i` high, `fault_en_o` equals exactly bit 0 set (value 1), from either state.
- R3: In `ST_RUN`, a cycle with `advance_i` high and `init_i` low moves the single set bit from position k to position k+1 at the next edge. At no time is more than one bit of `fault_en_o` high.
- R4: An advance taken at position N_FAULTS-1 returns the set bit to position 0. `last_fault_o` is high for exactly the one cycle after that edge, and is low in every other cycle.
- R5: When `init_i` and `advance_i` are high in the same cycle, `init_i` wins. The result is position 0 and no `last_fault_o` pulse.
- R6: In `ST_IDLE`, `advance_i` is ignored: `fault_en_o` stays all zero and `last_fault_o` stays 0.
- R7: For each position k whose `STUCK_POL[k]` bit is 1, `node_o[k] = node_i[k] | fault_en_o[k]`. The node is forced to 1 while its enable is high.
- R8: For each position k whose `STUCK_POL[k]` bit is 0, `node_o[k] = node_i[k] & ~fault_en_o[k]`. The node is forced to 0 while its enable is high.
- R9: `cell_o` is bit `cell_in_i` (read as an unsigned index 0..15) of `BAD_FN` while `fault_en_o[CELL_POS]` is 1, and of `GOOD_FN` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| init_i | input | 1 | Load position 0; takes priority over advance |
| advance_i | input | 1 | Rotate to the next fault position |
| node_i | input | N_FAULTS | Fault-free value of each sample node |
| cell_in_i | input | 4 | Inputs of the function-select cell |
| fault_en_o | output | N_FAULTS | One-hot (or zero) fault-enable vector |
| node_o | output | N_FAULTS | Sample nodes after the forcing gates |
| cell_o | output | 1 | Output of the function-select cell |
| last_fault_o | output | 1 | One-cycle pulse on wrap to position 0 |

## Verification
`fault_en_o` and `last_fault_o` are registered, so both show the effect of an `init_i` or `advance_i` one edge after the cycle in which the pulse is held. `node_o` and `cell_o` are combinational: they follow `node_i`, `cell_in_i` and the current enables in the same cycle. The bench drives every input on the falling edge. It compares at the next falling edge, which lies after exactly one rising edge. At that point its model has been advanced once for the registered outputs. The combinational outputs are compared against the inputs still being held.

// File: rtl/fltseq_pkg.sv
package fltseq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/onehot_ring.sv
module onehot_ring #(
    parameter int N_POS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    output logic [N_POS-1:0] ring_q,
    output logic             at_last
);

    localparam logic [N_POS-1:0] FIRST_POS = N_POS'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else if (load) begin
            ring_q <= FIRST_POS;
        end else if (shift) begin
            ring_q <= {ring_q[N_POS-2:0], ring_q[N_POS-1]};
        end
    end

    assign at_last = ring_q[N_POS-1];

    AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ring_q)); // R3

    AST_RING_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ring_q == FIRST_POS)); // R2

    AST_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (ring_q[0] == $past(ring_q[N_POS-1]))
                             && (ring_q[N_POS-1:1] == $past(ring_q[N_POS-2:0]))); // R3

endmodule

// File: rtl/stuck_gate.sv
module stuck_gate #(
    parameter bit STUCK_VAL = 1'b1
) (
    input  logic node_in,
    input  logic en,
    output logic node_out
);

    generate
        if (STUCK_VAL) begin : g_sa1
            assign node_out = node_in | en;
        end else begin : g_sa0
            assign node_out = node_in & ~en;
        end
    endgenerate

endmodule

// File: rtl/shannon_cell.sv
module shannon_cell #(
    parameter logic [15:0] GOOD_FN = 16'h6996,
    parameter logic [15:0] BAD_FN  = 16'h0FF0
) (
    input  logic [3:0] sel_in,
    input  logic       fault_sel,
    output logic       cell_out
);

    logic good_bit;
    logic bad_bit;

    assign good_bit = GOOD_FN[sel_in];
    assign bad_bit  = BAD_FN[sel_in];
    assign cell_out = fault_sel ? bad_bit : good_bit;

endmodule

// File: rtl/fault_seq_top.sv
module fault_seq_top #(
    parameter int                    N_FAULTS  = 6,
    parameter logic [N_FAULTS-1:0]   STUCK_POL = 6'b101010,
    parameter int                    CELL_POS  = 3,
    parameter logic [15:0]           GOOD_FN   = 16'h6996,
    parameter logic [15:0]           BAD_FN    = 16'h0FF0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_i,
    input  logic                advance_i,
    input  logic [N_FAULTS-1:0] node_i,
    input  logic [3:0]          cell_in_i,
    output logic [N_FAULTS-1:0] fault_en_o,
    output logic [N_FAULTS-1:0] node_o,
    output logic                cell_o,
    output logic                last_fault_o
);

    import fltseq_pkg::*;

    seq_state_t state_q;
    seq_state_t state_d;
    logic       ring_load;
    logic       ring_shift;
    logic       ring_last;
    logic       wrap_d;
    logic       wrap_q;

    // state register and wrap pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wrap_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wrap_q  <= wrap_d;
        end
    end

    // next state and control outputs
    always_comb begin
        state_d    = state_q;
        ring_load  = 1'b0;
        ring_shift = 1'b0;
        wrap_d     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (init_i) begin
                    ring_load = 1'b1;
                    state_d   = ST_RUN;
                end
            end
            ST_RUN: begin
                if (init_i) begin
                    ring_load = 1'b1;
                end else if (advance_i) begin
                    ring_shift = 1'b1;
                    wrap_d     = ring_last;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    onehot_ring #(
        .N_POS (N_FAULTS)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ring_load),
        .shift   (ring_shift),
        .ring_q  (fault_en_o),
        .at_last (ring_last)
    );

    assign last_fault_o = wrap_q;

    generate
        for (genvar k = 0; k < N_FAULTS; k++) begin : g_site
            stuck_gate #(
                .STUCK_VAL (STUCK_POL[k])
            ) u_gate (
                .node_in  (node_i[k]),
                .en       (fault_en_o[k]),
                .node_out (node_o[k])
            );

            AST_SITE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
                fault_en_o[k] |-> (node_o[k] == STUCK_POL[k])); // R7 R8

            AST_SITE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
                !fault_en_o[k] |-> (node_o[k] == node_i[k])); // R7 R8
        end
    endgenerate

    shannon_cell #(
        .GOOD_FN (GOOD_FN),
        .BAD_FN  (BAD_FN)
    ) u_cell (
        .sel_in    (cell_in_i),
        .fault_sel (fault_en_o[CELL_POS]),
        .cell_out  (cell_o)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (fault_en_o == '0) && !last_fault_o); // R6

    AST_WRAP_AT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        last_fault_o |-> fault_en_o[0]); // R4

    AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        last_fault_o |=> !last_fault_o || $past(advance_i && !init_i)); // R4

    AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && advance_i) |=> (fault_en_o == N_FAULTS'(1)) && !last_fault_o); // R5

    AST_RUN_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> $countones(fault_en_o) == 1); // R3

endmodule

// File: tb/fault_seq_top_test.sv
module fault_seq_top_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          NF         = 6;
    localparam logic [NF-1:0] POL      = 6'b101010;
    localparam int          CPOS       = 3;
    localparam logic [15:0] GFN        = 16'h6996;
    localparam logic [15:0] BFN        = 16'h0FF0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_i = 1'b0;
    logic          advance_i = 1'b0;
    logic [NF-1:0] node_i = '0;
    logic [3:0]    cell_in_i = '0;
    logic [NF-1:0] fault_en_o;
    logic [NF-1:0] node_o;
    logic          cell_o;
    logic          last_fault_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model: position -1 means no fault active
    int m_pos  = -1;
    bit m_wrap = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_seq_top #(
        .N_FAULTS  (NF),
        .STUCK_POL (POL),
        .CELL_POS  (CPOS),
        .GOOD_FN   (GFN),
        .BAD_FN    (BFN)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (init_i),
        .advance_i    (advance_i),
        .node_i       (node_i),
        .cell_in_i    (cell_in_i),
        .fault_en_o   (fault_en_o),
        .node_o       (node_o),
        .cell_o       (cell_o),
        .last_fault_o (last_fault_o)
    );

    function automatic logic [NF-1:0] exp_en(int pos);
        return (pos < 0) ? '0 : (NF'(1) << pos);
    endfunction

    function automatic logic [NF-1:0] exp_nodes(logic [NF-1:0] n, logic [NF-1:0] en);
        logic [NF-1:0] r;
        for (int k = 0; k < NF; k++)
            r[k] = POL[k] ? (n[k] | en[k]) : (n[k] & ~en[k]);
        return r;
    endfunction

    function automatic logic exp_cell(logic [3:0] idx, logic [NF-1:0] en);
        return en[CPOS] ? BFN[idx] : GFN[idx];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare all outputs against the model (called at a falling edge)
    task automatic check_all(string req_en);
        logic [NF-1:0] e;
        e = exp_en(m_pos);
        chk(req_en, 32'(fault_en_o), 32'(e));
        chk("R4 last_fault", 32'(last_fault_o), 32'(m_wrap));
        chk("R7/R8 node_o", 32'(node_o), 32'(exp_nodes(node_i, e)));
        chk("R9 cell_o", 32'(cell_o), 32'(exp_cell(cell_in_i, e)));
    endtask

    // drive one cycle of controls at a falling edge, advance model, check next falling edge
    task automatic step(bit ini, bit adv, logic [NF-1:0] nd, logic [3:0] ci, string req_en);
        init_i    = ini;
        advance_i = adv;
        node_i    = nd;
        cell_in_i = ci;
        if (ini) begin
            m_pos = 0; m_wrap = 1'b0;
        end else if (adv && m_pos >= 0) begin
            m_wrap = (m_pos == NF-1);
            m_pos  = (m_pos + 1) % NF;
        end else begin
            m_wrap = 1'b0;
        end
        @(negedge clk);
        check_all(req_en);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state with varied node and cell inputs
        node_i = 6'b110011; cell_in_i = 4'd5;
        #1;
        check_all("R1 reset enables");
        @(negedge clk);
        check_all("R1 reset enables");
        // R6: advance while idle is ignored
        step(1'b0, 1'b1, 6'b000000, 4'd3, "R6 idle advance");
        step(1'b0, 1'b1, 6'b111111, 4'd9, "R6 idle advance");
        // R2: init from idle
        step(1'b1, 1'b0, 6'b010101, 4'd1, "R2 init");
        // R3/R4: walk the whole ring and wrap
        for (int i = 0; i < NF; i++)
            step(1'b0, 1'b1, 6'(i * 11), 4'(i), "R3 R4 walk");
        step(1'b0, 1'b0, 6'b101010, 4'd7, "R4 pulse ends");
        // R5: init and advance together at the last position
        for (int i = 0; i < NF-1; i++)
            step(1'b0, 1'b1, 6'b0, 4'(i), "R3 walk");
        step(1'b1, 1'b1, 6'b111111, 4'd15, "R5 init wins");
        // R2: init while running from a middle position
        step(1'b0, 1'b1, 6'b0, 4'd2, "R3 step");
        step(1'b1, 1'b0, 6'b0, 4'd2, "R2 reinit");
        // R9: sweep cell inputs with the cell fault active and inactive
        for (int i = 0; i < 16; i++)
            step(1'b0, 1'b0, 6'b0, 4'(i), "R9 cell good");
        for (int i = 0; i < CPOS; i++)
            step(1'b0, 1'b1, 6'b111111, 4'd0, "R3 step");
        for (int i = 0; i < 16; i++)
            step(1'b0, 1'b0, 6'(i), 4'(i), "R9 cell bad");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit ini, adv;
            ini = ($urandom % 100) < 4;
            adv = ($urandom % 100) < 35;
            step(ini, adv, NF'($urandom), 4'($urandom), "R3 random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule